// File: doc/BRIEF.md
# Transmit Descriptor Ring Controller

This block walks a circular list of transmit descriptors in host memory. A descriptor is either handed to the device or kept by the host. The block gathers one or more buffers into a frame and streams their bytes into a transmit FIFO, marking the last byte of each frame. When it is done with a buffer, it writes that descriptor's control word back with the device-ownership flag cleared and any error flags set.

Host memory is reached through one word-wide port. Reads are combinational: the data and a parity-error flag belong to the address driven in the same cycle. Writes take effect at the clock edge. Memory is word addressed. Each buffer byte sits in the low eight bits of its own word.

Descriptor `i` occupies two words:
- The control word is at `cfg_ring_base + 2*i`.
- The buffer pointer is at the next address.

The transmitter is switched on by a start pulse. It stays on until an underflow occurs while recovery is disabled.

Top module: `tx_desc_ring`

## Requirements
- R1: While and directly after reset, `tx_on`, `fifo_valid` and `mem_we` are 0.
- R2: A pulse on `tx_start` sets `tx_on`. A descriptor whose control bit 31 (device owned) is 0 causes no FIFO output and no write to memory.
- R3: A descriptor with bit 31, bit 30 (frame start) and bit 29 (frame end) all set sends exactly L bytes, in address order, from its buffer. Here L is the two's complement of bits 11:0, and a count field of 0 means 4096. `fifo_last` is high only with the final byte.
- R4: A frame whose start descriptor has bit 29 clear continues into the following descriptors until one with bit 29 set has been sent. `fifo_last` is high only on the last byte of that final buffer.
- R5: At the start of a frame, a descriptor that is owned but has bit 30 clear is skipped and left unmodified.
- R6: Each descriptor the controller finishes is rewritten with bit 31 cleared. Bits 30, 29, 15:12 and 11:0 are not changed.
- R7: When a buffer without bit 29 has been sent and the next descriptor is not owned, the finished descriptor gets bit 27 (buffer error) and bit 26 (underflow) set. No `fifo_last` is given for that frame.
- R8: A `mac_uflo` pulse during a buffer transfer stops the transfer in that cycle, with no byte accepted. The current descriptor gets bit 26 set and bit 27 clear.
- R9: With `cfg_uflo_recover` at 0, an underflow or buffer error clears `tx_on`. No further descriptor is consumed until the next `tx_start`, which resumes at the following ring entry.
- R10: With `cfg_uflo_recover` at 1, after an underflow the controller keeps `tx_on` set. It skips the rest of the broken frame and sends the next descriptor that has bit 30 set.
- R11: Bit 28 (parity error) is written as 1 only when `cfg_par_en` is 1 and `mem_perr` was high on an accepted byte of that descriptor's buffer.
- R12: The ring index returns to entry 0 after entry `cfg_ring_len-1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ring_base | input | AW | Word address of descriptor 0 |
| cfg_ring_len | input | IW | Number of ring entries |
| cfg_par_en | input | 1 | Enables the parity-error descriptor flag |
| cfg_uflo_recover | input | 1 | 1: hunt for next frame after underflow; 0: stop |
| tx_start | input | 1 | Pulse that switches the transmitter on |
| tx_on | output | 1 | Transmitter is on |
| mem_addr | output | AW | Memory word address |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Combinational read data at `mem_addr` |
| mem_perr | input | 1 | Parity error on the current read |
| fifo_valid | output | 1 | Byte offered to the FIFO |
| fifo_data | output | DW | Byte value |
| fifo_last | output | 1 | Final byte of a frame |
| fifo_ready | input | 1 | FIFO accepts the byte this cycle |
| mac_uflo | input | 1 | Underflow reported by the MAC |

## Verification
The cycle costs are as follows:
- A frame costs one poll cycle and one pointer-load cycle before its first byte is offered.
- Each byte then takes one cycle per accepted handshake.
- The writeback of the control word lands on the edge after the final byte, or one cycle later when the next descriptor has to be checked.
- `tx_on` falls on the second edge after an unrecovered underflow.

The bench records the FIFO handshake one time unit before each rising edge, when the combinational outputs are settled. It injects underflow at a falling edge right after a counted byte, so the cut-off byte is exact. It compares memory words and byte lists only after a window of several dozen cycles, well past the longest of these latencies.

// File: rtl/tdr_pkg.sv
package tdr_pkg;

    localparam int WORD_W  = 32;
    localparam int CNT_W   = 12;
    localparam int LEN_W   = CNT_W + 1;

    localparam int OWN_B   = 31;
    localparam int SOF_B   = 30;
    localparam int EOF_B   = 29;
    localparam int PAR_B   = 28;
    localparam int BERR_B  = 27;
    localparam int UNDR_B  = 26;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POLL,
        ST_LOAD,
        ST_XFER,
        ST_NEXT,
        ST_WBACK
    } tdr_state_e;

    typedef enum logic [1:0] {
        ACT_POLL,
        ACT_LOAD,
        ACT_ERR
    } tdr_after_e;

    typedef struct packed {
        logic             own;
        logic             sof;
        logic             eof;
        logic [LEN_W-1:0] len;
    } tdr_ctl_t;

    // Two's-complement count field to byte length; zero means the full 4096.
    function automatic tdr_ctl_t decode_ctl(input logic [WORD_W-1:0] w);
        tdr_ctl_t   c;
        logic [CNT_W-1:0] mag;
        mag   = ~w[CNT_W-1:0] + 1'b1;
        c.own = w[OWN_B];
        c.sof = w[SOF_B];
        c.eof = w[EOF_B];
        c.len = (w[CNT_W-1:0] == '0) ? LEN_W'(1 << CNT_W) : {1'b0, mag};
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] status_word(
        input logic [WORD_W-1:0] w,
        input logic              par,
        input logic              berr,
        input logic              undr
    );
        logic [WORD_W-1:0] r;
        r         = w;
        r[OWN_B]  = 1'b0;
        r[PAR_B]  = par;
        r[BERR_B] = berr;
        r[UNDR_B] = undr;
        return r;
    endfunction

endpackage

// File: rtl/tdr_ring_ptr.sv
module tdr_ring_ptr #(
    parameter int IW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] ring_len,
    input  logic          adv,
    output logic [IW-1:0] idx,
    output logic [IW-1:0] idx_nxt
);

    logic [IW:0] inc;

    always_comb begin
        inc     = {1'b0, idx} + 1'b1;
        idx_nxt = (inc >= {1'b0, ring_len}) ? '0 : inc[IW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)      idx <= '0;
        else if (adv) idx <= idx_nxt;
    end

    a_r12_idx_in_ring: assert property (@(posedge clk) disable iff (rst)
        (ring_len != '0) |-> (idx < ring_len));

    a_r12_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        (adv && (ring_len != '0) && ({1'b0, idx} == {1'b0, ring_len} - 1'b1)) |=> (idx == '0));

endmodule

// File: rtl/tdr_buf_mover.sv
module tdr_buf_mover #(
    parameter int AW = 16,
    parameter int LW = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] ptr_in,
    input  logic [LW-1:0] len_in,
    input  logic          step,
    output logic [AW-1:0] ptr,
    output logic          last
);

    logic [LW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr    <= '0;
            remain <= '0;
        end else if (load) begin
            ptr    <= ptr_in;
            remain <= len_in;
        end else if (step) begin
            ptr    <= ptr + 1'b1;
            remain <= remain - 1'b1;
        end
    end

    assign last = (remain == LW'(1));

    a_r3_no_step_past_end: assert property (@(posedge clk) disable iff (rst)
        step |-> (remain != '0));

    a_r3_step_counts_down: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (remain == $past(remain) - 1'b1));

endmodule

// File: rtl/tx_desc_ring.sv
module tx_desc_ring
    import tdr_pkg::*;
#(
    parameter int AW = 16,
    parameter int IW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] cfg_ring_base,
    input  logic [IW-1:0] cfg_ring_len,
    input  logic          cfg_par_en,
    input  logic          cfg_uflo_recover,
    input  logic          tx_start,
    output logic          tx_on,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    input  logic          mem_perr,
    output logic          fifo_valid,
    output logic [DW-1:0] fifo_data,
    output logic          fifo_last,
    input  logic          fifo_ready,
    input  logic          mac_uflo
);

    localparam int LW = LEN_W;

    tdr_state_e st, st_n;
    tdr_after_e after;
    tdr_ctl_t   rd;

    logic          cur_eof;
    logic [LW-1:0] cur_len;
    logic          par_acc, e_berr, e_undr;
    logic          ring_adv, mv_load, mv_step, mv_last;
    logic [IW-1:0] idx, idx_nxt;
    logic [AW-1:0] mv_ptr, a_ctl, a_ptr, a_ctl_nxt;

    tdr_ring_ptr #(.IW(IW)) u_ring (
        .clk      (clk),
        .rst      (rst),
        .ring_len (cfg_ring_len),
        .adv      (ring_adv),
        .idx      (idx),
        .idx_nxt  (idx_nxt)
    );

    tdr_buf_mover #(.AW(AW), .LW(LW)) u_mover (
        .clk    (clk),
        .rst    (rst),
        .load   (mv_load),
        .ptr_in (mem_rdata[AW-1:0]),
        .len_in (cur_len),
        .step   (mv_step),
        .ptr    (mv_ptr),
        .last   (mv_last)
    );

    always_comb begin
        a_ctl     = cfg_ring_base + AW'({idx, 1'b0});
        a_ptr     = a_ctl + 1'b1;
        a_ctl_nxt = cfg_ring_base + AW'({idx_nxt, 1'b0});
        rd        = decode_ctl(mem_rdata);
        fifo_data = mem_rdata[DW-1:0];
    end

    always_comb begin
        st_n       = st;
        mem_addr   = a_ctl;
        mem_we     = 1'b0;
        mem_wdata  = '0;
        fifo_valid = 1'b0;
        fifo_last  = 1'b0;
        ring_adv   = 1'b0;
        mv_load    = 1'b0;
        mv_step    = 1'b0;
        case (st)
            ST_IDLE: begin
                if (tx_on) st_n = ST_POLL;
            end
            ST_POLL: begin
                if (rd.own) begin
                    if (rd.sof) st_n     = ST_LOAD;
                    else        ring_adv = 1'b1;
                end
            end
            ST_LOAD: begin
                mem_addr = a_ptr;
                mv_load  = 1'b1;
                st_n     = ST_XFER;
            end
            ST_XFER: begin
                mem_addr = mv_ptr;
                if (mac_uflo) begin
                    st_n = ST_WBACK;
                end else begin
                    fifo_valid = 1'b1;
                    fifo_last  = mv_last & cur_eof;
                    if (fifo_ready) begin
                        mv_step = 1'b1;
                        if (mv_last) st_n = cur_eof ? ST_WBACK : ST_NEXT;
                    end
                end
            end
            ST_NEXT: begin
                mem_addr = a_ctl_nxt;
                st_n     = ST_WBACK;
            end
            ST_WBACK: begin
                mem_we    = 1'b1;
                mem_wdata = status_word(mem_rdata, par_acc, e_berr, e_undr);
                ring_adv  = 1'b1;
                case (after)
                    ACT_LOAD: st_n = ST_LOAD;
                    ACT_POLL: st_n = ST_POLL;
                    default:  st_n = cfg_uflo_recover ? ST_POLL : ST_IDLE;
                endcase
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            after   <= ACT_POLL;
            tx_on   <= 1'b0;
            cur_eof <= 1'b0;
            cur_len <= '0;
            par_acc <= 1'b0;
            e_berr  <= 1'b0;
            e_undr  <= 1'b0;
        end else begin
            st <= st_n;
            if (tx_start) tx_on <= 1'b1;
            case (st)
                ST_POLL: begin
                    if (rd.own && rd.sof) begin
                        cur_eof <= rd.eof;
                        cur_len <= rd.len;
                    end
                end
                ST_LOAD: begin
                    par_acc <= 1'b0;
                    e_berr  <= 1'b0;
                    e_undr  <= 1'b0;
                end
                ST_XFER: begin
                    if (mac_uflo) begin
                        e_undr <= 1'b1;
                        after  <= ACT_ERR;
                    end else if (fifo_ready) begin
                        if (mem_perr && cfg_par_en) par_acc <= 1'b1;
                        if (mv_last && cur_eof)    after   <= ACT_POLL;
                    end
                end
                ST_NEXT: begin
                    if (mac_uflo || !rd.own) begin
                        e_berr <= 1'b1;
                        e_undr <= 1'b1;
                        after  <= ACT_ERR;
                    end else begin
                        cur_eof <= rd.eof;
                        cur_len <= rd.len;
                        after   <= ACT_LOAD;
                    end
                end
                ST_WBACK: begin
                    if (after == ACT_ERR && !cfg_uflo_recover) tx_on <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    a_r6_release_clears_own: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !mem_wdata[OWN_B]);

    a_r7_berr_implies_undr: assert property (@(posedge clk) disable iff (rst)
        (mem_we && mem_wdata[BERR_B]) |-> mem_wdata[UNDR_B]);

    a_r11_par_needs_enable: assert property (@(posedge clk) disable iff (rst)
        (mem_we && mem_wdata[PAR_B]) |-> cfg_par_en);

    a_r3_last_needs_valid: assert property (@(posedge clk) disable iff (rst)
        fifo_last |-> fifo_valid);

    a_r2_valid_only_when_on: assert property (@(posedge clk) disable iff (rst)
        fifo_valid |-> tx_on);

    a_r8_no_byte_on_uflo: assert property (@(posedge clk) disable iff (rst)
        mac_uflo |-> !fifo_valid);

    a_r9_uflo_turns_off: assert property (@(posedge clk) disable iff (rst)
        (fifo_valid == 1'b0 && st == ST_XFER && mac_uflo && !cfg_uflo_recover) |-> ##2 !tx_on);

endmodule

// File: tb/tb_tx_desc_ring.sv
module tb_tx_desc_ring;

    localparam int CLK_P = 10;
    localparam int AW    = 16;
    localparam int IW    = 8;
    localparam int DW    = 8;
    localparam logic [AW-1:0] RB   = 16'h0040;
    localparam int            BUFB = 16'h0200;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] cfg_ring_base = RB;
    logic [IW-1:0] cfg_ring_len  = 8'd4;
    logic          cfg_par_en = 1'b0;
    logic          cfg_uflo_recover = 1'b0;
    logic          tx_start = 1'b0;
    logic          tx_on;
    logic [AW-1:0] mem_addr;
    logic          mem_we;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata;
    logic          mem_perr;
    logic          fifo_valid;
    logic [DW-1:0] fifo_data;
    logic          fifo_last;
    logic          fifo_ready = 1'b1;
    logic          mac_uflo = 1'b0;
    logic          stall = 1'b0;

    logic [31:0] mem  [0:1023];
    logic        perr [0:1023];
    logic [7:0]  got  [0:127];
    int nb = 0;
    int last_cnt = 0;
    int last_pos = -1;
    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    assign mem_rdata = mem[mem_addr[9:0]];
    assign mem_perr  = perr[mem_addr[9:0]];

    always @(posedge clk) if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;

    always @(negedge clk) fifo_ready <= stall ? ~fifo_ready : 1'b1;

    always @(negedge clk) begin
        #(CLK_P/2 - 1);
        if (fifo_valid && fifo_ready) begin
            if (nb < 128) got[nb] = fifo_data;
            if (fifo_last) begin
                last_cnt++;
                last_pos = nb;
            end
            nb++;
        end
    end

    tx_desc_ring #(.AW(AW), .IW(IW), .DW(DW)) dut (
        .clk(clk), .rst(rst),
        .cfg_ring_base(cfg_ring_base), .cfg_ring_len(cfg_ring_len),
        .cfg_par_en(cfg_par_en), .cfg_uflo_recover(cfg_uflo_recover),
        .tx_start(tx_start), .tx_on(tx_on),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_perr(mem_perr),
        .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_last(fifo_last),
        .fifo_ready(fifo_ready), .mac_uflo(mac_uflo)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    function automatic logic [31:0] ctl_word(input bit own, input bit sof, input bit eof, input int len);
        logic [11:0] c;
        c = 12'(4096 - len);
        return {own, sof, eof, 3'b000, 10'd0, 4'hF, c};
    endfunction

    function automatic logic [31:0] released(input logic [31:0] w, input bit par, input bit berr, input bit undr);
        logic [31:0] r;
        r = w;
        r[31] = 1'b0; r[28] = par; r[27] = berr; r[26] = undr;
        return r;
    endfunction

    task automatic put_desc(input int i, input bit own, input bit sof, input bit eof, input int len, input logic [7:0] seed);
        mem[RB + 2*i]     = ctl_word(own, sof, eof, len);
        mem[RB + 2*i + 1] = 32'(BUFB + 32*i);
        for (int k = 0; k < len; k++) mem[BUFB + 32*i + k] = {24'h0, 8'(seed + k)};
    endtask

    function automatic logic [31:0] ctl_of(input int i);
        return mem[RB + 2*i];
    endfunction

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reset_dut;
        @(negedge clk);
        rst = 1'b1; tx_start = 1'b0; mac_uflo = 1'b0; stall = 1'b0;
        for (int a = 0; a < 1024; a++) begin mem[a] = 32'h0; perr[a] = 1'b0; end
        run(2);
        nb = 0; last_cnt = 0; last_pos = -1;
        rst = 1'b0;
    endtask

    task automatic start_tx;
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
    endtask

    task automatic uflo_after(input int k);
        while (nb < k) @(negedge clk);
        mac_uflo = 1'b1;
        @(negedge clk);
        mac_uflo = 1'b0;
    endtask

    task automatic chk_bytes(input string req, input int from, input int cnt, input logic [7:0] seed);
        for (int k = 0; k < cnt; k++) chk(req, {24'h0, got[from + k]}, {24'h0, 8'(seed + k)});
    endtask

    task automatic t_reset;
        rst = 1'b1;
        run(2);
        chk("R1 tx_on", {31'h0, tx_on}, 32'h0);
        chk("R1 fifo_valid", {31'h0, fifo_valid}, 32'h0);
        chk("R1 mem_we", {31'h0, mem_we}, 32'h0);
        rst = 1'b0;
        run(1);
        chk("R1 tx_on after release", {31'h0, tx_on}, 32'h0);
    endtask

    task automatic t_unowned;
        reset_dut();
        put_desc(0, 0, 1, 1, 3, 8'h11);
        start_tx();
        run(30);
        chk("R2 tx_on set", {31'h0, tx_on}, 32'h1);
        chk("R2 no bytes", nb, 0);
        chk("R2 desc untouched", ctl_of(0), ctl_word(0, 1, 1, 3));
    endtask

    task automatic t_single;
        reset_dut();
        put_desc(0, 1, 1, 1, 5, 8'hA0);
        start_tx();
        run(40);
        chk("R3 byte count", nb, 5);
        chk_bytes("R3 data", 0, 5, 8'hA0);
        chk("R3 one last", last_cnt, 1);
        chk("R3 last pos", last_pos, 4);
        chk("R6 released", ctl_of(0), released(ctl_word(1, 1, 1, 5), 0, 0, 0));
    endtask

    task automatic t_chain;
        reset_dut();
        put_desc(0, 1, 1, 0, 3, 8'h10);
        put_desc(1, 1, 0, 0, 1, 8'h20);
        put_desc(2, 1, 0, 1, 4, 8'h30);
        stall = 1'b1;
        start_tx();
        run(80);
        stall = 1'b0;
        chk("R4 byte count", nb, 8);
        chk_bytes("R4 buf0", 0, 3, 8'h10);
        chk_bytes("R4 buf1", 3, 1, 8'h20);
        chk_bytes("R4 buf2", 4, 4, 8'h30);
        chk("R4 one last", last_cnt, 1);
        chk("R4 last pos", last_pos, 7);
        chk("R6 desc0", ctl_of(0), released(ctl_word(1, 1, 0, 3), 0, 0, 0));
        chk("R6 desc1", ctl_of(1), released(ctl_word(1, 0, 0, 1), 0, 0, 0));
        chk("R6 desc2", ctl_of(2), released(ctl_word(1, 0, 1, 4), 0, 0, 0));
    endtask

    task automatic t_skip;
        reset_dut();
        put_desc(0, 1, 0, 1, 2, 8'h50);
        put_desc(1, 1, 1, 1, 3, 8'h60);
        start_tx();
        run(40);
        chk("R5 byte count", nb, 3);
        chk_bytes("R5 data", 0, 3, 8'h60);
        chk("R5 skipped desc unchanged", ctl_of(0), ctl_word(1, 0, 1, 2));
        chk("R5 sent desc released", ctl_of(1), released(ctl_word(1, 1, 1, 3), 0, 0, 0));
    endtask

    task automatic t_missing;
        reset_dut();
        put_desc(0, 1, 1, 0, 3, 8'h70);
        put_desc(1, 0, 0, 1, 2, 8'h78);
        start_tx();
        run(40);
        chk("R7 bytes before stop", nb, 3);
        chk("R7 no last", last_cnt, 0);
        chk("R7 status", ctl_of(0), released(ctl_word(1, 1, 0, 3), 0, 1, 1));
        chk("R9 off after buffer error", {31'h0, tx_on}, 32'h0);
    endtask

    task automatic t_uflo_off;
        reset_dut();
        put_desc(0, 1, 1, 1, 6, 8'h80);
        put_desc(1, 1, 1, 1, 2, 8'h90);
        start_tx();
        uflo_after(2);
        run(40);
        chk("R8 truncated", nb, 2);
        chk("R8 status", ctl_of(0), released(ctl_word(1, 1, 1, 6), 0, 0, 1));
        chk("R9 tx_on off", {31'h0, tx_on}, 32'h0);
        chk("R9 next untouched", ctl_of(1), ctl_word(1, 1, 1, 2));
        start_tx();
        run(40);
        chk("R9 resumed count", nb, 4);
        chk_bytes("R9 resumed data", 2, 2, 8'h90);
        chk("R9 resumed last", last_cnt, 1);
    endtask

    task automatic t_uflo_rec;
        reset_dut();
        cfg_uflo_recover = 1'b1;
        put_desc(0, 1, 1, 0, 4, 8'hC0);
        put_desc(1, 1, 0, 1, 4, 8'hC8);
        put_desc(2, 1, 1, 1, 2, 8'hD0);
        start_tx();
        uflo_after(2);
        run(40);
        chk("R10 byte count", nb, 4);
        chk_bytes("R10 new frame", 2, 2, 8'hD0);
        chk("R10 one last", last_cnt, 1);
        chk("R10 tx_on kept", {31'h0, tx_on}, 32'h1);
        chk("R10 broken desc", ctl_of(0), released(ctl_word(1, 1, 0, 4), 0, 0, 1));
        chk("R10 remainder skipped", ctl_of(1), ctl_word(1, 0, 1, 4));
        cfg_uflo_recover = 1'b0;
    endtask

    task automatic t_parity;
        reset_dut();
        cfg_par_en = 1'b1;
        put_desc(0, 1, 1, 1, 4, 8'hE0);
        put_desc(1, 1, 1, 1, 2, 8'hE8);
        perr[BUFB + 2] = 1'b1;
        start_tx();
        run(50);
        chk("R11 flagged", ctl_of(0), released(ctl_word(1, 1, 1, 4), 1, 0, 0));
        chk("R11 clean", ctl_of(1), released(ctl_word(1, 1, 1, 2), 0, 0, 0));
        reset_dut();
        cfg_par_en = 1'b0;
        put_desc(0, 1, 1, 1, 4, 8'hE0);
        perr[BUFB + 2] = 1'b1;
        start_tx();
        run(40);
        chk("R11 disabled", ctl_of(0), released(ctl_word(1, 1, 1, 4), 0, 0, 0));
    endtask

    task automatic t_wrap;
        reset_dut();
        cfg_ring_len = 8'd2;
        put_desc(0, 1, 1, 1, 2, 8'h01);
        put_desc(1, 1, 1, 1, 2, 8'h05);
        start_tx();
        run(40);
        chk("R12 first lap", nb, 4);
        put_desc(0, 1, 1, 1, 3, 8'h30);
        run(40);
        chk("R12 after wrap", nb, 7);
        chk_bytes("R12 wrapped data", 4, 3, 8'h30);
        chk("R12 wrapped desc released", ctl_of(0), released(ctl_word(1, 1, 1, 3), 0, 0, 0));
        cfg_ring_len = 8'd4;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        report();
        $finish;
    end

    initial begin
        for (int a = 0; a < 1024; a++) begin mem[a] = 32'h0; perr[a] = 1'b0; end
        t_reset();
        t_unowned();
        t_single();
        t_chain();
        t_skip();
        t_missing();
        t_uflo_off();
        t_uflo_rec();
        t_parity();
        t_wrap();
        report();
        $finish;
    end

endmodule